// File: doc/BRIEF.md
# Segment Capability Translation Cache

This block turns a capability-based virtual address into a physical memory request. It holds a set of evaluated segment capabilities, each tagged by two things: the number of the cache register that holds the capability for its containing capability segment, and its index within that segment. A small tag memory maps each active capability segment of the running process to the cache register that holds that segment's own capability. Because of this indirection, an entry stays valid across a domain switch: only the tag memory has to be rewritten.

A lookup picks a tag memory register with the top address bits. It then scans the entries four at a time, comparing the segment tag with the tag memory contents and the capability tag with the address's index field. On a match it checks the requested access against the stored rights and the offset against the stored size. It then answers with either a physical address (base plus offset) or a protection fault. When nothing matches, or the selected tag memory register is empty, it answers with a miss. An external controller then fills entries and tag memory registers through a load port.

Top module: `cap_xlate_cache`

## Requirements
- R1: The virtual address has three fields. Bits 31:28 select the tag memory register, bits 23:16 are the 8-bit capability index and bits 15:0 are the word offset. Bits 27:24 have no effect on the result.
- R2: A tag memory write stores the 6-bit register number in register `ldTagIdx` and marks it valid. Reset marks all 16 tag memory registers invalid.
- R3: An entry write stores the capability tag, segment tag, 20-bit base, 16-bit size and 7-bit rights, clears that entry's reference count and marks the entry valid. Reset marks every entry invalid.
- R4: An entry matches when it is valid, its segment tag equals the selected tag memory contents and its capability tag equals the capability index. When several entries match, the lowest-numbered one is used.
- R5: A request whose selected tag memory register is invalid is answered with a miss in the first cycle after the accepting edge, without any search.
- R6: The search examines 4 entries per cycle in ascending order. A match at entry e is answered e/4+2 cycles after the accepting edge. When no entry matches, the miss is answered 17 cycles after that edge.
- R7: `reqAccess` bit 0 requests read, bit 1 write and bit 2 execute, and stored rights bits 2:0 grant the same three. A matched request that asks for any bit not granted is answered with a fault.
- R8: A matched request whose offset is greater than or equal to the stored size is answered with a fault. An offset of size-1 is allowed.
- R9: A matched request that passes both checks is answered with a hit and `memAddr` = (base + offset) mod 2^20.
- R10: A hit increments the entry's reference count, which saturates at 127, and `respCount` reports the new value. Faults and misses leave the count unchanged.
- R11: `respValid` is a one-cycle pulse with exactly one of `respHit`, `respMiss`, `respFault`. All three flags are low without it, and `memAddr` and `respCount` are zero except with a hit.
- R12: `busy` is high during a search, and a request presented while busy is ignored. A tag memory write made during a search does not change that search's result but does apply to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request, accepted when `busy` is low |
| reqAddr | input | 32 | Virtual address |
| reqAccess | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| busy | output | 1 | Search in progress |
| respValid | output | 1 | Response pulse |
| respHit | output | 1 | Translation succeeded |
| respMiss | output | 1 | No usable entry; controller must load |
| respFault | output | 1 | Protection fault (rights or size) |
| memAddr | output | 20 | Physical word address on a hit |
| respCount | output | 7 | Updated reference count on a hit |
| ldEntryValid | input | 1 | Write one cache entry |
| ldEntryIdx | input | 6 | Entry number to write |
| ldCapTag | input | 8 | Capability index within its segment |
| ldSegTag | input | 6 | Register number holding the containing segment's capability |
| ldBase | input | 20 | Segment base |
| ldSize | input | 16 | Segment size in words |
| ldRights | input | 7 | Rights field; bits 2:0 are read, write, execute |
| ldTagValid | input | 1 | Write one tag memory register |
| ldTagIdx | input | 4 | Capability segment number |
| ldTagReg | input | 6 | Register number to store |

## Verification
The assertions check on every cycle that each response carries exactly one outcome and that the address and count stay zero unless there is a hit. They also check that a request to an empty tag memory register is answered with a miss one cycle later, that a search never runs longer than 16 busy cycles, and that `busy` only rises on an accepted request. The bench scenarios cover the rest. Scan-order priority among duplicate matches, exact latencies by entry position, the rights and size boundaries, base wrap-around and count saturation are all checked against a model. A dedicated scenario rewrites tag memory and presents a second request in the middle of a search, to show that the running search keeps its snapshot and that the extra request is dropped.

// File: rtl/cap_xlate_pkg.sv
package cap_xlate_pkg;
  localparam int CAP_TAG_W = 8;
  localparam int BASE_W    = 20;
  localparam int SIZE_W    = 16;
  localparam int RIGHTS_W  = 7;
  localparam int COUNT_W   = 7;
  localparam int OFFSET_W  = 16;
  localparam int ACC_W     = 3;

  typedef struct packed {
    logic [CAP_TAG_W-1:0] capTag;
    logic [BASE_W-1:0]    base;
    logic [SIZE_W-1:0]    size;
    logic [RIGHTS_W-1:0]  rights;
    logic [COUNT_W-1:0]   count;
  } entry_t;

  typedef struct packed {
    logic latchReq;  // capture request fields and tag memory snapshot
    logic doneHit;   // matched entry in current group: resolve
    logic doneMiss;  // answer with a miss
  } strobes_t;
endpackage

// File: rtl/cap_xlate_ctrl.sv
module cap_xlate_ctrl import cap_xlate_pkg::*; #(
  parameter  int NUM_GROUPS = 16,
  localparam int GRP_W      = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             selTagValid,
  input  logic             groupHit,
  output strobes_t         strb,
  output logic [GRP_W-1:0] grpIdx,
  output logic             busy
);
  typedef enum logic {ST_IDLE, ST_SEARCH} state_t;
  state_t state, stateNext;
  logic   lastGroup;

  assign lastGroup = (grpIdx == GRP_W'(NUM_GROUPS - 1));
  assign busy      = (state == ST_SEARCH);

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          if (!selTagValid) strb.doneMiss = 1'b1;
          else              stateNext     = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (groupHit) begin
          strb.doneHit = 1'b1;
          stateNext    = ST_IDLE;
        end else if (lastGroup) begin
          strb.doneMiss = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      grpIdx <= '0;
    end else begin
      state <= stateNext;
      if (strb.latchReq)                      grpIdx <= '0;
      else if (busy && stateNext == ST_SEARCH) grpIdx <= grpIdx + 1'b1;
    end
  end
endmodule

// File: rtl/cap_xlate_dp.sv
module cap_xlate_dp import cap_xlate_pkg::*; #(
  parameter  int NUM_ENTRIES = 64,
  parameter  int NUM_SEGS    = 16,
  parameter  int LANES       = 4,
  localparam int ENT_W       = $clog2(NUM_ENTRIES),
  localparam int SEL_W       = $clog2(NUM_SEGS),
  localparam int LANE_W      = $clog2(LANES),
  localparam int GRP_W       = ENT_W - LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [GRP_W-1:0]     grpIdx,
  input  logic [31:0]          reqAddr,
  input  logic [ACC_W-1:0]     reqAccess,
  input  logic                 ldEntryValid,
  input  logic [ENT_W-1:0]     ldEntryIdx,
  input  logic [CAP_TAG_W-1:0] ldCapTag,
  input  logic [ENT_W-1:0]     ldSegTag,
  input  logic [BASE_W-1:0]    ldBase,
  input  logic [SIZE_W-1:0]    ldSize,
  input  logic [RIGHTS_W-1:0]  ldRights,
  input  logic                 ldTagValid,
  input  logic [SEL_W-1:0]     ldTagIdx,
  input  logic [ENT_W-1:0]     ldTagReg,
  output logic                 selTagValid,
  output logic                 groupHit,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 respMiss,
  output logic                 respFault,
  output logic [BASE_W-1:0]    memAddr,
  output logic [COUNT_W-1:0]   respCount
);
  entry_t                 ent    [NUM_ENTRIES];
  logic [ENT_W-1:0]       entSeg [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entVld;
  logic [ENT_W-1:0]       tagReg [NUM_SEGS];
  logic [NUM_SEGS-1:0]    tagVld;

  // request snapshot taken at acceptance
  logic [ENT_W-1:0]     lSeg;
  logic [CAP_TAG_W-1:0] lCap;
  logic [OFFSET_W-1:0]  lOffset;
  logic [ACC_W-1:0]     lAccess;

  logic [SEL_W-1:0]  selIdx;
  logic [LANES-1:0]  laneMatch;
  logic [LANE_W-1:0] hitLane;
  logic [ENT_W-1:0]  hitIdx;
  entry_t            hitEnt;
  logic              isFault, cntBump;
  logic [COUNT_W-1:0] nextCount;

  assign selIdx      = reqAddr[31 -: SEL_W];
  assign selTagValid = tagVld[selIdx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ENT_W-1:0] laneIdx;
    assign laneIdx      = {grpIdx, LANE_W'(l)};
    assign laneMatch[l] = entVld[laneIdx] && (entSeg[laneIdx] == lSeg) &&
                          (ent[laneIdx].capTag == lCap);
  end

  always_comb begin
    hitLane = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (laneMatch[l]) hitLane = LANE_W'(l);
  end

  assign groupHit  = |laneMatch;
  assign hitIdx    = {grpIdx, hitLane};
  assign hitEnt    = ent[hitIdx];
  assign isFault   = (lOffset >= hitEnt.size) ||
                     ((lAccess & ~hitEnt.rights[ACC_W-1:0]) != '0);
  assign nextCount = (&hitEnt.count) ? hitEnt.count : hitEnt.count + 1'b1;
  assign cntBump   = strb.doneHit && !isFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagVld <= '0;
      for (int s = 0; s < NUM_SEGS; s++) tagReg[s] <= '0;
      lSeg <= '0; lCap <= '0; lOffset <= '0; lAccess <= '0;
    end else begin
      if (strb.latchReq) begin
        lSeg    <= tagReg[selIdx];
        lCap    <= reqAddr[23:16];
        lOffset <= reqAddr[OFFSET_W-1:0];
        lAccess <= reqAccess;
      end
      if (ldTagValid) begin
        tagReg[ldTagIdx] <= ldTagReg;
        tagVld[ldTagIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entVld <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        ent[e]    <= '0;
        entSeg[e] <= '0;
      end
    end else begin
      if (cntBump) ent[hitIdx].count <= nextCount;
      if (ldEntryValid) begin
        entVld[ldEntryIdx]   <= 1'b1;
        entSeg[ldEntryIdx]   <= ldSegTag;
        ent[ldEntryIdx].capTag <= ldCapTag;
        ent[ldEntryIdx].base   <= ldBase;
        ent[ldEntryIdx].size   <= ldSize;
        ent[ldEntryIdx].rights <= ldRights;
        ent[ldEntryIdx].count  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0; respHit <= 1'b0; respMiss <= 1'b0; respFault <= 1'b0;
      memAddr   <= '0;   respCount <= '0;
    end else begin
      respValid <= strb.doneHit | strb.doneMiss;
      respMiss  <= strb.doneMiss;
      respHit   <= cntBump;
      respFault <= strb.doneHit && isFault;
      memAddr   <= cntBump ? hitEnt.base + {{(BASE_W-OFFSET_W){1'b0}}, lOffset} : '0;
      respCount <= cntBump ? nextCount : '0;
    end
  end
endmodule

// File: rtl/cap_xlate_cache.sv
module cap_xlate_cache import cap_xlate_pkg::*; #(
  parameter  int NUM_ENTRIES = 64,
  parameter  int NUM_SEGS    = 16,
  parameter  int LANES       = 4,
  localparam int ENT_W       = $clog2(NUM_ENTRIES),
  localparam int SEL_W       = $clog2(NUM_SEGS),
  localparam int NUM_GROUPS  = NUM_ENTRIES / LANES,
  localparam int GRP_W       = $clog2(NUM_GROUPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [31:0]          reqAddr,
  input  logic [ACC_W-1:0]     reqAccess,
  output logic                 busy,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 respMiss,
  output logic                 respFault,
  output logic [BASE_W-1:0]    memAddr,
  output logic [COUNT_W-1:0]   respCount,
  input  logic                 ldEntryValid,
  input  logic [ENT_W-1:0]     ldEntryIdx,
  input  logic [CAP_TAG_W-1:0] ldCapTag,
  input  logic [ENT_W-1:0]     ldSegTag,
  input  logic [BASE_W-1:0]    ldBase,
  input  logic [SIZE_W-1:0]    ldSize,
  input  logic [RIGHTS_W-1:0]  ldRights,
  input  logic                 ldTagValid,
  input  logic [SEL_W-1:0]     ldTagIdx,
  input  logic [ENT_W-1:0]     ldTagReg
);
  strobes_t         strb;
  logic [GRP_W-1:0] grpIdx;
  logic             selTagValid, groupHit;

  cap_xlate_ctrl #(.NUM_GROUPS(NUM_GROUPS)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .selTagValid(selTagValid),
    .groupHit(groupHit), .strb(strb), .grpIdx(grpIdx), .busy(busy)
  );

  cap_xlate_dp #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_SEGS(NUM_SEGS), .LANES(LANES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grpIdx(grpIdx),
    .reqAddr(reqAddr), .reqAccess(reqAccess),
    .ldEntryValid(ldEntryValid), .ldEntryIdx(ldEntryIdx), .ldCapTag(ldCapTag),
    .ldSegTag(ldSegTag), .ldBase(ldBase), .ldSize(ldSize), .ldRights(ldRights),
    .ldTagValid(ldTagValid), .ldTagIdx(ldTagIdx), .ldTagReg(ldTagReg),
    .selTagValid(selTagValid), .groupHit(groupHit),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respFault(respFault), .memAddr(memAddr), .respCount(respCount)
  );
endmodule

// File: rtl/cap_xlate_chk.sv
module cap_xlate_chk #(
  parameter  int NUM_SEGS   = 16,
  parameter  int NUM_GROUPS = 16,
  localparam int SEL_W      = $clog2(NUM_SEGS),
  localparam int CNT_W      = $clog2(NUM_GROUPS) + 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [31:0]      reqAddr,
  input logic             busy,
  input logic             respValid,
  input logic             respHit,
  input logic             respMiss,
  input logic             respFault,
  input logic [19:0]      memAddr,
  input logic [6:0]       respCount,
  input logic             ldTagValid,
  input logic [SEL_W-1:0] ldTagIdx
);
  logic [NUM_SEGS-1:0] shVld;
  logic [CNT_W-1:0]    busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shVld   <= '0;
      busyCnt <= '0;
    end else begin
      if (ldTagValid) shVld[ldTagIdx] <= 1'b1;
      if (busy) busyCnt <= busyCnt + 1'b1;
      else      busyCnt <= '0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respHit, respMiss, respFault}) == 1); // R11
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respFault)); // R11
  AST_ZERO_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (memAddr == '0 && respCount == '0)); // R11
  AST_HIT_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respCount != '0); // R10
  AST_EMPTY_TAG_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !shVld[reqAddr[31 -: SEL_W]]) |=> (respValid && respMiss)); // R5
  AST_VALID_TAG_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && shVld[reqAddr[31 -: SEL_W]]) |=> (busy && !respValid)); // R6
  AST_BOUNDED_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < CNT_W'(NUM_GROUPS)); // R6
  AST_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy); // R12
  AST_BUSY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid)); // R12
endmodule

bind cap_xlate_cache cap_xlate_chk #(.NUM_SEGS(NUM_SEGS), .NUM_GROUPS(NUM_GROUPS)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .busy(busy),
  .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
  .respFault(respFault), .memAddr(memAddr), .respCount(respCount),
  .ldTagValid(ldTagValid), .ldTagIdx(ldTagIdx)
);

// File: tb/test_cap_xlate_cache.sv
`timescale 1ns/1ps
module test_cap_xlate_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqAccess = '0;
  logic        busy, respValid, respHit, respMiss, respFault;
  logic [19:0] memAddr;
  logic [6:0]  respCount;
  logic        ldEntryValid = 1'b0;
  logic [5:0]  ldEntryIdx = '0;
  logic [7:0]  ldCapTag = '0;
  logic [5:0]  ldSegTag = '0;
  logic [19:0] ldBase = '0;
  logic [15:0] ldSize = '0;
  logic [6:0]  ldRights = '0;
  logic        ldTagValid = 1'b0;
  logic [3:0]  ldTagIdx = '0;
  logic [5:0]  ldTagReg = '0;

  always #2.5 clk = ~clk;

  cap_xlate_cache i_cap_xlate_cache (.*);

  int nChecks = 0, nFails = 0;

  // bench model
  logic [7:0]  mCap [64];
  logic [5:0]  mSeg [64];
  logic [19:0] mBase[64];
  logic [15:0] mSize[64];
  logic [6:0]  mRts [64];
  logic [6:0]  mCnt [64];
  logic [63:0] mVld = '0;
  logic [5:0]  tagR [16];
  logic [15:0] tagV = '0;

  typedef struct { int kind; int lat; logic [19:0] phys; logic [6:0] cnt; int idx; } exp_t;
  // kind: 0 miss, 1 hit, 2 fault

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(logic [31:0] a, logic [2:0] acc);
    exp_t x;
    int sel = int'(a[31:28]);
    x.kind = 0; x.lat = 1; x.phys = '0; x.cnt = '0; x.idx = -1;
    if (!tagV[sel]) return x;
    x.lat = 17;
    for (int e = 0; e < 64; e++)
      if (x.idx < 0 && mVld[e] && mSeg[e] == tagR[sel] && mCap[e] == a[23:16]) x.idx = e;
    if (x.idx < 0) return x;
    x.lat = x.idx / 4 + 2;
    if (a[15:0] >= mSize[x.idx] || (acc & ~mRts[x.idx][2:0]) != 3'b000) begin
      x.kind = 2;
    end else begin
      x.kind = 1;
      x.phys = mBase[x.idx] + {4'h0, a[15:0]};
      x.cnt  = (mCnt[x.idx] == 7'h7F) ? 7'h7F : mCnt[x.idx] + 7'd1;
    end
    return x;
  endfunction

  task automatic loadTag(int s, int r);
    @(negedge clk);
    ldTagValid = 1'b1; ldTagIdx = 4'(s); ldTagReg = 6'(r);
    @(negedge clk);
    ldTagValid = 1'b0;
    tagR[s] = 6'(r); tagV[s] = 1'b1;
  endtask

  task automatic loadEnt(int e, int cap, int seg, int base, int size, int rts);
    @(negedge clk);
    ldEntryValid = 1'b1; ldEntryIdx = 6'(e); ldCapTag = 8'(cap); ldSegTag = 6'(seg);
    ldBase = 20'(base); ldSize = 16'(size); ldRights = 7'(rts);
    @(negedge clk);
    ldEntryValid = 1'b0;
    mCap[e] = 8'(cap); mSeg[e] = 6'(seg); mBase[e] = 20'(base);
    mSize[e] = 16'(size); mRts[e] = 7'(rts); mCnt[e] = '0; mVld[e] = 1'b1;
  endtask

  function automatic int outKind();
    if (respHit) return 1;
    if (respFault) return 2;
    if (respMiss) return 0;
    return 3;
  endfunction

  task automatic compare(exp_t x, int lat, string req);
    check(outKind() == x.kind, req, "outcome", outKind(), x.kind);
    check(lat == x.lat, req, "latency", lat, x.lat);
    check(memAddr == x.phys, req, "memAddr", memAddr, x.phys);
    check(respCount == x.cnt, req, "respCount", respCount, x.cnt);
    if (x.kind == 1) mCnt[x.idx] = x.cnt;
  endtask

  task automatic waitResp(output int lat);
    lat = 1;
    while (!respValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic lookup(logic [31:0] a, logic [2:0] acc, string req);
    exp_t x;
    int lat;
    x = predict(a, acc);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
    waitResp(lat);
    compare(x, lat, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    exp_t x;
    int lat;
    int unsigned seedV = 32'h5EED_0C47;
    void'($urandom(seedV));
    for (int s = 0; s < 16; s++) tagR[s] = '0;
    for (int e = 0; e < 64; e++) mCnt[e] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state R11
    check(!respValid && !busy && memAddr == 0, "R11", "reset outputs",
          {respValid, busy}, 0);
    // R2: all tag registers invalid after reset -> immediate miss (R5)
    lookup(32'h3055_0010, 3'b001, "R2");
    lookup(32'hF000_0000, 3'b001, "R5");

    // directed setup
    loadTag(3, 10);
    loadEnt(10, 3, 0, 20'h00000, 16'h0400, 7'h03);
    loadEnt(21, 8'h55, 10, 20'h12340, 16'h0100, 7'h03);
    lookup(32'h3055_0010, 3'b001, "R4");       // hit at entry 21, latency 7 (R6)
    lookup(32'h3F55_0010, 3'b011, "R1");       // bits 27:24 ignored
    lookup(32'h3055_0020, 3'b100, "R7");       // execute not granted
    lookup(32'h3055_0100, 3'b001, "R8");       // offset == size
    lookup(32'h3055_00FF, 3'b001, "R8");       // offset == size-1
    lookup(32'h3056_0000, 3'b001, "R6");       // no match -> 17
    loadEnt(20, 8'h55, 10, 20'h00500, 16'h0100, 7'h07);
    lookup(32'h3055_0004, 3'b111, "R4");       // lowest index wins
    loadEnt(5, 8'h55, 10, 20'h00600, 16'h0100, 7'h07);
    lookup(32'h3055_0004, 3'b010, "R6");       // entry 5, latency 3
    loadEnt(5, 8'h55, 11, 20'h00600, 16'h0100, 7'h07);
    loadEnt(20, 8'h55, 11, 20'h00500, 16'h0100, 7'h07);
    loadEnt(33, 8'h9A, 10, 20'hFFFF0, 16'h0040, 7'h01);
    lookup(32'h309A_0020, 3'b001, "R9");       // base wraps modulo 2^20
    for (int i = 0; i < 130; i++) lookup(32'h3055_0001, 3'b001, "R10");
    check(mCnt[21] == 7'h7F, "R10", "model saturation", mCnt[21], 127);
    lookup(32'h3055_0100, 3'b001, "R10");      // fault leaves count
    lookup(32'h3055_0001, 3'b001, "R10");      // still 127
    loadEnt(21, 8'h55, 10, 20'h12340, 16'h0100, 7'h03);
    lookup(32'h3055_0002, 3'b001, "R3");       // reload clears count -> 1

    // R12: mid-search tag write and ignored request
    loadEnt(61, 8'h77, 10, 20'h0A000, 16'h1000, 7'h07);
    x = predict(32'h3077_0008, 3'b001);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h3077_0008; reqAccess = 3'b001;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'hF000_0000; reqAccess = 3'b001;
    ldTagValid = 1'b1; ldTagIdx = 4'd3; ldTagReg = 6'd11;
    @(negedge clk);
    reqValid = 1'b0; ldTagValid = 1'b0;
    tagR[3] = 6'd11;
    lat = 2;
    while (!respValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    compare(x, lat, "R12");
    @(negedge clk);
    check(!respValid && !busy, "R12", "ignored request produced activity",
          {respValid, busy}, 0);
    lookup(32'h3077_0008, 3'b001, "R12");      // new tag -> entries 5,20 tagged 11 differ in cap
    lookup(32'h3055_0003, 3'b001, "R12");      // tag 11 matches entry 5 now

    // constrained random
    for (int s = 0; s < 12; s++) loadTag(s, $urandom_range(0, 63));
    for (int e = 0; e < 64; e++)
      loadEnt(e, $urandom_range(0, 7), tagR[$urandom_range(0, 11)],
              $urandom_range(0, 20'hFFFFF), $urandom_range(1, 16'hFFFF),
              $urandom_range(0, 127));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [2:0]  acc;
      a = $urandom;
      a[23:16] = 8'($urandom_range(0, 9));
      if ($urandom_range(0, 1) == 1) a[15:0] = 16'($urandom_range(0, 255));
      acc = ($urandom_range(0, 1) == 1) ? 3'b001 : 3'($urandom_range(0, 7));
      lookup(a, acc, (i % 2 == 0) ? "R4" : "R9");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule